// File: doc/BRIEF.md
# System Control and Reset-Cause Register File

This block is a small bank of byte-wide I/O registers that sits on a 16-bit port address bus next to the processor. It keeps a record of why the machine last came out of reset (a software-requested reset or a reset reported by the CPU). Software reads that record and the read clears it. The block also drives the software reset request, the power-off and shutdown request, and the NMI-vector protection flag.

The same register file holds the flags that steer the memory map: whether DMA targets video memory, the dictionary and ROM bank selects, and the character-generator enable. It gates an external NMI source through an active-low mask. It gives software direct bit-level control of a serial configuration ROM. Fixed identification ports report a machine ID whose three low bits are replaced by a CPU code.

Every port address, the machine ID, the CPU code and the presence of the power-off status bit are parameters. All register updates happen on the rising clock edge while the write strobe is high. A read returns the current register contents combinationally while the read strobe is high. Clear-on-read side effects take place on the clock edge that ends the read cycle.

Top module: `sysctl_regs`

## Requirements
- R1: A read of the reset-cause port (default 0x0020) returns bit0 = software-reset flag, bit1 = reset-occurred flag and bit2 = power-off status (always 0 when HAS_POFF is 0), with the other bits 0. The clock edge that ends the read clears the software-reset flag, the reset-occurred flag and `shutdown`.
- R2: A write to the reset-cause port sets `nmi_protect` from data bit7 and the software-reset flag from bit0. It sets `shutdown` from bit6. A 1 in bit6 also sets the power-off status, which stays set until block reset.
- R3: In the DMA-target port (default 0x0404), bit7 is active-low. Writing 0 drives `dma_to_vram` high. The port reads 0x00 when video memory is the target and 0x80 otherwise.
- R4: In the bank port (default 0x0480), bit0 = 1 selects dictionary mapping (`dict_sel`) and bit1 = 0 selects ROM mapping (`rom_sel`). A read returns {6'b0, ~rom_sel, dict_sel}.
- R5: In the NMI-mask port (default 0x05C0), bit3 is active-low: writing 0 masks the NMI. The port reads 0x00 when the NMI is masked and 0x08 when it is unmasked. `nmi_out` equals the latched NMI level AND NOT masked.
- R6: `ext_nmi` is latched on every clock edge. The NMI-status port (default 0x05C2) returns the latched level in bit3 and 0 elsewhere. Writes to this port have no effect.
- R7: A write to the serial-ROM port (default 0x0032) drives `sprom_cs` from inverted bit5, `sprom_clk` from bit6 and `sprom_rst` from bit7. A read returns {sprom_rst, sprom_clk, 5'b0, sprom_din}.
- R8: A high `cpu_reset_note` sets the reset-occurred flag, clears `nmi_protect`, `cg_enable` and `dict_sel`, and sets `rom_sel`. It takes priority over a write in the same cycle.
- R9: The machine-ID low port (default 0x0030) returns {MACHINE_ID[7:3], CPU_CODE}. The high port (0x0031) returns MACHINE_ID[15:8]. Writes to these ports have no effect.
- R10: In the character-generator port (default 0xFF99), bit0 sets `cg_enable`. A read returns {7'b0, cg_enable}.
- R11: Reads of any other address return 0xFF. Writes to any other address change no output and no readback.
- R12: After block reset: all flags are 0, `rom_sel` = 1, the NMI is masked, `dma_to_vram` = 0 and the serial-ROM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| io_addr | input | AW (16) | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port |
| cpu_reset_note | input | 1 | CPU reports it has been reset |
| ext_nmi | input | 1 | External NMI source level |
| sprom_din | input | 1 | Serial ROM data line |
| nmi_out | output | 1 | Gated NMI to the CPU |
| shutdown | output | 1 | Power-off / CPU shutdown request |
| nmi_protect | output | 1 | NMI vector protection |
| dma_to_vram | output | 1 | DMA targets video memory |
| dict_sel | output | 1 | Dictionary bank mapped |
| rom_sel | output | 1 | ROM bank mapped |
| cg_enable | output | 1 | Character-generator enable |
| sprom_cs | output | 1 | Serial ROM chip select |
| sprom_clk | output | 1 | Serial ROM clock |
| sprom_rst | output | 1 | Serial ROM reset |

## Verification
Some properties hold on every cycle and are checked there:
- the inverted polarity of the DMA-target bit and the serial-ROM chip select,
- the clearing of the reset record on the edge after a reset-cause read,
- the bank and flag state after a CPU reset notification,
- the relation of `nmi_out` to the NMI level sampled one cycle earlier and to the mask.

Other behaviour only shows up across sequences, so the bench's scenarios cover it:
- the sticky power-off status surviving clear-on-read,
- reads returning 0xFF on unmapped addresses,
- writes to read-only and unmapped ports changing nothing,
- the replacement of the machine-ID low bits by the CPU code.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned DW = 8;
   typedef logic [DW-1:0] byte_t;

   typedef enum logic [3:0] {
      PORT_NONE,
      PORT_RCAUSE,
      PORT_MID_LO,
      PORT_MID_HI,
      PORT_SPROM,
      PORT_DMA,
      PORT_BANK,
      PORT_NMI_MASK,
      PORT_NMI_STAT,
      PORT_CGEN
   } port_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter logic [15:0] ADDR_RCAUSE = 16'h0020,
   parameter logic [15:0] ADDR_MID    = 16'h0030,
   parameter logic [15:0] ADDR_SPROM  = 16'h0032,
   parameter logic [15:0] ADDR_DMA    = 16'h0404,
   parameter logic [15:0] ADDR_BANK   = 16'h0480,
   parameter logic [15:0] ADDR_NMIMSK = 16'h05C0,
   parameter logic [15:0] ADDR_NMISTA = 16'h05C2,
   parameter logic [15:0] ADDR_CGEN   = 16'hFF99
) (
   input  logic [AW-1:0] addr,
   output port_e         port
);
   localparam logic [AW-1:0] A_RC  = AW'(ADDR_RCAUSE);
   localparam logic [AW-1:0] A_ML  = AW'(ADDR_MID);
   localparam logic [AW-1:0] A_MH  = AW'(ADDR_MID + 16'd1);
   localparam logic [AW-1:0] A_SP  = AW'(ADDR_SPROM);
   localparam logic [AW-1:0] A_DM  = AW'(ADDR_DMA);
   localparam logic [AW-1:0] A_BK  = AW'(ADDR_BANK);
   localparam logic [AW-1:0] A_NM  = AW'(ADDR_NMIMSK);
   localparam logic [AW-1:0] A_NS  = AW'(ADDR_NMISTA);
   localparam logic [AW-1:0] A_CG  = AW'(ADDR_CGEN);

   always_comb begin
      if      (addr == A_RC) port = PORT_RCAUSE;
      else if (addr == A_ML) port = PORT_MID_LO;
      else if (addr == A_MH) port = PORT_MID_HI;
      else if (addr == A_SP) port = PORT_SPROM;
      else if (addr == A_DM) port = PORT_DMA;
      else if (addr == A_BK) port = PORT_BANK;
      else if (addr == A_NM) port = PORT_NMI_MASK;
      else if (addr == A_NS) port = PORT_NMI_STAT;
      else if (addr == A_CG) port = PORT_CGEN;
      else                   port = PORT_NONE;
   end
endmodule

// File: rtl/sysctl_rcause.sv
module sysctl_rcause
   import sysctl_pkg::*;
#(
   parameter bit HAS_POFF = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_hit,
   input  logic  rd_hit,
   input  byte_t wdata,
   input  logic  reset_note,
   output byte_t rdata,
   output logic  shutdown,
   output logic  nmi_protect
);
   logic occ_q;
   logic sw_q;
   logic shdn_q;
   logic prot_q;
   logic poff_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q  <= 1'b0;
         sw_q   <= 1'b0;
         shdn_q <= 1'b0;
         prot_q <= 1'b0;
      end else begin
         if (reset_note)  occ_q <= 1'b1;
         else if (rd_hit) occ_q <= 1'b0;

         if (wr_hit)      sw_q <= wdata[0];
         else if (rd_hit) sw_q <= 1'b0;

         if (wr_hit)      shdn_q <= wdata[6];
         else if (rd_hit) shdn_q <= 1'b0;

         if (reset_note)  prot_q <= 1'b0;
         else if (wr_hit) prot_q <= wdata[7];
      end
   end

   generate
      if (HAS_POFF) begin : g_poff
         always_ff @(posedge clk) begin
            if (!rst_n)                  poff_q <= 1'b0;
            else if (wr_hit && wdata[6]) poff_q <= 1'b1;
         end
      end else begin : g_no_poff
         assign poff_q = 1'b0;
      end
   endgenerate

   assign rdata       = {5'b0, poff_q, occ_q, sw_q};
   assign shutdown    = shdn_q;
   assign nmi_protect = prot_q;

   // R1
   rcause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !wr_hit && !reset_note) |=> (!occ_q && !sw_q && !shutdown));

   // R8
   note_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_note |=> (occ_q && !nmi_protect));

   // R2
   prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !reset_note) |=> (nmi_protect == $past(wdata[7])));
endmodule

// File: rtl/sysctl_mapctl.sv
module sysctl_mapctl
   import sysctl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr,
   input  port_e port,
   input  byte_t wdata,
   input  logic  reset_note,
   input  logic  ext_nmi,
   input  logic  sprom_din,
   output byte_t rdata,
   output logic  nmi_out,
   output logic  dma_to_vram,
   output logic  dict_sel,
   output logic  rom_sel,
   output logic  cg_enable,
   output logic  sprom_cs,
   output logic  sprom_clk,
   output logic  sprom_rst
);
   logic dma_q, dict_q, rom_q, cg_q, mask_q, lvl_q;
   logic cs_q, sclk_q, srst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_q  <= 1'b0;
         dict_q <= 1'b0;
         rom_q  <= 1'b1;
         cg_q   <= 1'b0;
         mask_q <= 1'b1;
         lvl_q  <= 1'b0;
         cs_q   <= 1'b0;
         sclk_q <= 1'b0;
         srst_q <= 1'b0;
      end else begin
         lvl_q <= ext_nmi;
         if (reset_note) begin
            dict_q <= 1'b0;
            rom_q  <= 1'b1;
            cg_q   <= 1'b0;
         end else if (wr) begin
            if (port == PORT_BANK) begin
               dict_q <= wdata[0];
               rom_q  <= ~wdata[1];
            end
            if (port == PORT_CGEN) cg_q <= wdata[0];
         end
         if (wr) begin
            case (port)
               PORT_DMA:      dma_q  <= ~wdata[7];
               PORT_NMI_MASK: mask_q <= ~wdata[3];
               PORT_SPROM: begin
                  cs_q   <= ~wdata[5];
                  sclk_q <= wdata[6];
                  srst_q <= wdata[7];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (port)
         PORT_SPROM:    rdata = {srst_q, sclk_q, 5'b0, sprom_din};
         PORT_DMA:      rdata = dma_q ? 8'h00 : 8'h80;
         PORT_BANK:     rdata = {6'b0, ~rom_q, dict_q};
         PORT_NMI_MASK: rdata = mask_q ? 8'h00 : 8'h08;
         PORT_NMI_STAT: rdata = {4'b0, lvl_q, 3'b0};
         PORT_CGEN:     rdata = {7'b0, cg_q};
         default:       rdata = 8'hFF;
      endcase
   end

   assign nmi_out     = lvl_q & ~mask_q;
   assign dma_to_vram = dma_q;
   assign dict_sel    = dict_q;
   assign rom_sel     = rom_q;
   assign cg_enable   = cg_q;
   assign sprom_cs    = cs_q;
   assign sprom_clk   = sclk_q;
   assign sprom_rst   = srst_q;

   // R3
   dma_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && port == PORT_DMA) |=> (dma_to_vram == !$past(wdata[7])));

   // R7
   sprom_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && port == PORT_SPROM) |=> (sprom_cs == !$past(wdata[5])));

   // R8
   note_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_note |=> (rom_sel && !dict_sel && !cg_enable));

   // R5
   nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && nmi_out) |-> ($past(ext_nmi) && !$past(mask_q) ? 1'b1 : !mask_q));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter logic [15:0] MACHINE_ID  = 16'h0B4D,
   parameter logic [2:0]  CPU_CODE    = 3'd2,
   parameter bit          HAS_POFF    = 1'b1,
   parameter logic [15:0] ADDR_RCAUSE = 16'h0020,
   parameter logic [15:0] ADDR_MID    = 16'h0030,
   parameter logic [15:0] ADDR_SPROM  = 16'h0032,
   parameter logic [15:0] ADDR_DMA    = 16'h0404,
   parameter logic [15:0] ADDR_BANK   = 16'h0480,
   parameter logic [15:0] ADDR_NMIMSK = 16'h05C0,
   parameter logic [15:0] ADDR_NMISTA = 16'h05C2,
   parameter logic [15:0] ADDR_CGEN   = 16'hFF99
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] io_addr,
   input  logic          io_rd,
   input  logic          io_wr,
   input  logic [7:0]    io_wdata,
   output logic [7:0]    io_rdata,
   input  logic          cpu_reset_note,
   input  logic          ext_nmi,
   input  logic          sprom_din,
   output logic          nmi_out,
   output logic          shutdown,
   output logic          nmi_protect,
   output logic          dma_to_vram,
   output logic          dict_sel,
   output logic          rom_sel,
   output logic          cg_enable,
   output logic          sprom_cs,
   output logic          sprom_clk,
   output logic          sprom_rst
);
   localparam byte_t MID_LO = {MACHINE_ID[7:3], CPU_CODE};
   localparam byte_t MID_HI = MACHINE_ID[15:8];

   generate
      if (AW < 16) begin : g_bad_aw
         $error("sysctl_regs: address width must be at least 16");
      end
      if (ADDR_RCAUSE == ADDR_DMA || ADDR_RCAUSE == ADDR_BANK ||
          ADDR_DMA == ADDR_BANK || ADDR_NMIMSK == ADDR_NMISTA ||
          ADDR_SPROM == ADDR_MID || ADDR_SPROM == ADDR_MID + 16'd1 ||
          ADDR_CGEN == ADDR_BANK) begin : g_bad_map
         $error("sysctl_regs: port addresses overlap");
      end
   endgenerate

   port_e port;
   byte_t rc_rdata;
   byte_t mc_rdata;
   logic  rc_wr, rc_rd;

   sysctl_decode #(
      .AW(AW), .ADDR_RCAUSE(ADDR_RCAUSE), .ADDR_MID(ADDR_MID),
      .ADDR_SPROM(ADDR_SPROM), .ADDR_DMA(ADDR_DMA), .ADDR_BANK(ADDR_BANK),
      .ADDR_NMIMSK(ADDR_NMIMSK), .ADDR_NMISTA(ADDR_NMISTA), .ADDR_CGEN(ADDR_CGEN)
   ) u_dec (
      .addr (io_addr),
      .port (port)
   );

   assign rc_wr = io_wr && (port == PORT_RCAUSE);
   assign rc_rd = io_rd && (port == PORT_RCAUSE);

   sysctl_rcause #(.HAS_POFF(HAS_POFF)) u_rc (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (rc_wr),
      .rd_hit      (rc_rd),
      .wdata       (io_wdata),
      .reset_note  (cpu_reset_note),
      .rdata       (rc_rdata),
      .shutdown    (shutdown),
      .nmi_protect (nmi_protect)
   );

   sysctl_mapctl u_mc (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (io_wr),
      .port        (port),
      .wdata       (io_wdata),
      .reset_note  (cpu_reset_note),
      .ext_nmi     (ext_nmi),
      .sprom_din   (sprom_din),
      .rdata       (mc_rdata),
      .nmi_out     (nmi_out),
      .dma_to_vram (dma_to_vram),
      .dict_sel    (dict_sel),
      .rom_sel     (rom_sel),
      .cg_enable   (cg_enable),
      .sprom_cs    (sprom_cs),
      .sprom_clk   (sprom_clk),
      .sprom_rst   (sprom_rst)
   );

   always_comb begin
      case (port)
         PORT_RCAUSE: io_rdata = rc_rdata;
         PORT_MID_LO: io_rdata = MID_LO;
         PORT_MID_HI: io_rdata = MID_HI;
         default:     io_rdata = mc_rdata;
      endcase
   end
endmodule

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] MID = 16'h0B4D;
   localparam logic [2:0]  CPU = 3'd2;

   localparam logic [15:0] A_RC = 16'h0020, A_ML = 16'h0030, A_MH = 16'h0031,
                           A_SP = 16'h0032, A_DM = 16'h0404, A_BK = 16'h0480,
                           A_NM = 16'h05C0, A_NS = 16'h05C2, A_CG = 16'hFF99,
                           A_X1 = 16'h0021, A_X2 = 16'h1234;

   logic clk = 0, rst_n = 0;
   logic [15:0] io_addr = '0;
   logic io_rd = 0, io_wr = 0;
   logic [7:0] io_wdata = '0, io_rdata;
   logic cpu_reset_note = 0, ext_nmi = 0, sprom_din = 0;
   logic nmi_out, shutdown, nmi_protect, dma_to_vram, dict_sel, rom_sel, cg_enable;
   logic sprom_cs, sprom_clk, sprom_rst;

   int total = 0, bad = 0;

   // reference state
   logic m_occ, m_sw, m_shdn, m_prot, m_poff, m_dma, m_dict, m_rom, m_cg, m_mask, m_lvl;
   logic m_cs, m_sclk, m_srst;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_regs #(.MACHINE_ID(MID), .CPU_CODE(CPU)) u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_reset_note(cpu_reset_note),
      .ext_nmi(ext_nmi), .sprom_din(sprom_din), .nmi_out(nmi_out), .shutdown(shutdown),
      .nmi_protect(nmi_protect), .dma_to_vram(dma_to_vram), .dict_sel(dict_sel),
      .rom_sel(rom_sel), .cg_enable(cg_enable), .sprom_cs(sprom_cs),
      .sprom_clk(sprom_clk), .sprom_rst(sprom_rst));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      case (a)
         A_RC: return {5'b0, m_poff, m_occ, m_sw};
         A_ML: return {MID[7:3], CPU};
         A_MH: return MID[15:8];
         A_SP: return {m_srst, m_sclk, 5'b0, sprom_din};
         A_DM: return m_dma ? 8'h00 : 8'h80;
         A_BK: return {6'b0, ~m_rom, m_dict};
         A_NM: return m_mask ? 8'h00 : 8'h08;
         A_NS: return {4'b0, m_lvl, 3'b0};
         A_CG: return {7'b0, m_cg};
         default: return 8'hFF;
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      case (a)
         A_RC: return "R1";
         A_ML, A_MH: return "R9";
         A_SP: return "R7";
         A_DM: return "R3";
         A_BK: return "R4";
         A_NM: return "R5";
         A_NS: return "R6";
         A_CG: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic model_reset();
      m_occ = 0; m_sw = 0; m_shdn = 0; m_prot = 0; m_poff = 0; m_dma = 0;
      m_dict = 0; m_rom = 1; m_cg = 0; m_mask = 1; m_lvl = 0;
      m_cs = 0; m_sclk = 0; m_srst = 0;
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " R2 shutdown"},    {7'b0, shutdown},    {7'b0, m_shdn});
      chk({tag, " R2 protect"},     {7'b0, nmi_protect}, {7'b0, m_prot});
      chk({tag, " R3 dma"},         {7'b0, dma_to_vram}, {7'b0, m_dma});
      chk({tag, " R4 bank"},        {6'b0, rom_sel, dict_sel}, {6'b0, m_rom, m_dict});
      chk({tag, " R10 cg"},         {7'b0, cg_enable},   {7'b0, m_cg});
      chk({tag, " R5 nmi_out"},     {7'b0, nmi_out},     {7'b0, m_lvl & ~m_mask});
      chk({tag, " R7 sprom"},       {5'b0, sprom_rst, sprom_clk, sprom_cs},
                                    {5'b0, m_srst, m_sclk, m_cs});
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1;
      @(negedge clk);
      io_wr = 0;
      case (a)
         A_RC: begin m_prot = d[7]; m_sw = d[0]; m_shdn = d[6]; if (d[6]) m_poff = 1; end
         A_DM: m_dma = ~d[7];
         A_BK: begin m_dict = d[0]; m_rom = ~d[1]; end
         A_NM: m_mask = ~d[3];
         A_SP: begin m_cs = ~d[5]; m_sclk = d[6]; m_srst = d[7]; end
         A_CG: m_cg = d[0];
         default: ;
      endcase
   endtask

   task automatic io_read(input logic [15:0] a);
      @(negedge clk);
      io_addr = a; io_rd = 1;
      #1 chk(tag_of(a), io_rdata, exp_read(a));
      @(negedge clk);
      io_rd = 0;
      if (a == A_RC) begin m_occ = 0; m_sw = 0; m_shdn = 0; end
   endtask

   task automatic set_nmi(input logic v);
      @(negedge clk);
      ext_nmi = v;
      @(negedge clk);
      m_lvl = v;
   endtask

   task automatic reset_note();
      @(negedge clk);
      cpu_reset_note = 1;
      @(negedge clk);
      cpu_reset_note = 0;
      m_occ = 1; m_prot = 0; m_cg = 0; m_dict = 0; m_rom = 1;
   endtask

   function automatic logic [15:0] pick_addr(input int k);
      case (k)
         0: return A_RC;  1: return A_ML;  2: return A_MH;  3: return A_SP;
         4: return A_DM;  5: return A_BK;  6: return A_NM;  7: return A_NS;
         8: return A_CG;  9: return A_X1;  default: return A_X2;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      @(negedge clk);
      check_outs("R12");
      io_read(A_RC); io_read(A_DM); io_read(A_BK); io_read(A_NM); io_read(A_SP);

      // R1 R2: set sw reset, shutdown, protect; clear-on-read keeps power-off
      io_write(A_RC, 8'hC1);
      check_outs("R2");
      io_read(A_RC);
      check_outs("R1 after read");
      io_read(A_RC);
      // R8 reset notification
      io_write(A_BK, 8'h01); io_write(A_CG, 8'h01); io_write(A_RC, 8'h80);
      reset_note();
      check_outs("R8");
      io_read(A_RC); io_read(A_BK); io_read(A_CG);
      // R9 read-only machine id ports ignore writes
      io_write(A_ML, 8'h00); io_write(A_MH, 8'hAA);
      io_read(A_ML); io_read(A_MH);
      // R5 R6 NMI gating
      set_nmi(1); check_outs("R5 masked"); io_read(A_NS);
      io_write(A_NM, 8'h08); check_outs("R5 unmasked"); io_read(A_NM);
      io_write(A_NS, 8'h00); io_read(A_NS);
      set_nmi(0); check_outs("R6 low");
      // R7 serial ROM with data line
      sprom_din = 1; io_write(A_SP, 8'hC0); check_outs("R7"); io_read(A_SP);
      sprom_din = 0; io_write(A_SP, 8'h20); io_read(A_SP);
      // R11 unmapped ports
      io_write(A_X2, 8'hFF); io_write(A_X1, 8'h00); check_outs("R11");
      io_read(A_X2); io_read(A_X1);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom % 12;
         if (op < 6) io_write(pick_addr($urandom % 11), 8'($urandom));
         else if (op < 9) io_read(pick_addr($urandom % 11));
         else if (op < 11) set_nmi(1'($urandom));
         else reset_note();
         sprom_din = 1'($urandom);
         #1 check_outs("rand");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule